// File: doc/BRIEF.md
# Descriptor-Chain DMA Channel Sequencer

This block is the control half of a single DMA channel. Software places a chain of descriptors in memory, writes the address of the first one into the channel and sets the run bit. The channel reads each descriptor word by word over a simple request/acknowledge read port. It then hands the transfer to an external data mover and waits for the mover to finish. After that it follows the link field to the next descriptor, and it stops when the link holds the end-of-chain marker.

Each descriptor is six 32-bit words at consecutive word addresses. The words are packed configuration, source address, destination address, byte count, parameter word and link. The configuration word is split into a source half and a destination half. The channel decodes both halves into request line, fixed-address flag, burst length in beats and element size in bytes, and places them beside the raw words on the mover interface. Two event pulses mark the end of one descriptor and the end of the whole chain. A pause bit holds back new work without cutting off the transfer in flight, and clearing the run bit abandons the chain at once. The actual data copy is left to the mover.

Top module: `llist_dma_chan`

## Requirements
- R1: After reset the channel is idle. Register offset 0x00 and the package counter at offset 0x30 read 0, and mem_req, mv_start, pkg_done and queue_done are low.
- R2: Writing 1 to bit 0 of offset 0x00 while idle starts a fetch at the address held at offset 0x08. Six words are read at that address plus 0, 4, 8, 12, 16 and 20, in the order config, source, destination, count, parameter, link. mem_addr stays stable while mem_req is high and no mem_ack has come.
- R3: After the sixth word, mv_start is high for exactly one cycle. mv_cfg, mv_src, mv_dst, mv_len and mv_para carry the descriptor words. Offsets 0x0C, 0x10, 0x14 and 0x1C read back the config, source, destination and parameter words.
- R4: Config bits [15:0] describe the source side and bits [31:16] the destination side. Within each half, [4:0] is the request line, [6:5] the address mode (1 = fixed, anything else incrementing), [8:7] the burst code (0,1,2,3 = 1,4,8,16 beats) and [10:9] the width code (0,1,2,3 = 1,2,4,8 bytes). Parameter bits [15:8] appear on mv_blk_size and bits [7:0] on mv_wait.
- R5: Each mv_done from the mover produces a one-cycle pkg_done in the following cycle. The package counter at offset 0x30 then counts the finished descriptors, and it is cleared by the start write.
- R6: A link value other than 0xFFFFF800 makes the channel fetch the next descriptor at that address. Offset 0x2C reads the address of the descriptor being processed.
- R7: When the finished descriptor's link is 0xFFFFF800, queue_done pulses in the same cycle as pkg_done, and offset 0x00 reads 0 from then on.
- R8: While bit 0 of offset 0x04 is 1, no descriptor fetch begins and no mv_start is issued. A mover transfer already started still completes with its pkg_done. Clearing the bit resumes the chain.
- R9: Writing 0 to bit 0 of offset 0x00 makes the channel idle in the next cycle. mem_req and mv_start are low, offset 0x00 reads 0, and a later mv_done produces no pulse.
- R10: Offset 0x18 reads the descriptor's byte count while its transfer is outstanding and 0 once that transfer is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write offset |
| reg_wdata | input | 32 | Register write data |
| reg_rd_addr | input | 8 | Register read offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Descriptor word byte address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 32 | Read data |
| mv_start | output | 1 | One-cycle transfer start to the mover |
| mv_cfg | output | 32 | Raw config word |
| mv_src | output | 32 | Source address |
| mv_dst | output | 32 | Destination address |
| mv_len | output | 32 | Byte count |
| mv_para | output | 32 | Raw parameter word |
| mv_src_line | output | 5 | Source request line |
| mv_src_fixed | output | 1 | Source address is fixed |
| mv_src_beats | output | 5 | Source burst length in beats |
| mv_src_bytes | output | 4 | Source element size in bytes |
| mv_dst_line | output | 5 | Destination request line |
| mv_dst_fixed | output | 1 | Destination address is fixed |
| mv_dst_beats | output | 5 | Destination burst length in beats |
| mv_dst_bytes | output | 4 | Destination element size in bytes |
| mv_blk_size | output | 8 | Data block size |
| mv_wait | output | 8 | Wait cycles |
| mv_done | input | 1 | Mover finished the started transfer |
| pkg_done | output | 1 | One descriptor finished |
| queue_done | output | 1 | Last descriptor of the chain finished |

## Verification
Each descriptor word is taken on the edge that carries its mem_ack, and mv_start rises in the cycle after the sixth acknowledge. pkg_done and queue_done appear one cycle after the mv_done edge, and the run bit and package counter change on that same edge. A stop write takes effect on the edge that samples it. The bench records mover starts, memory reads and event pulses in logs at fixed points of the clock, and it reads registers only at the falling edge after the edge that was meant to update them. When a check needs something to be absent, it waits a window many times longer than the mover latency and then compares the log counts.

// File: rtl/llist_dma_chan.sv
module llist_dma_chan #(
  parameter int DW = 32,
  parameter int RA_W = 8,
  parameter int CNT_W = 16,
  parameter logic [DW-1:0] END_MARK = 32'hFFFF_F800
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr_en,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  input  logic [RA_W-1:0] reg_rd_addr,
  output logic [DW-1:0]   reg_rdata,
  output logic            mem_req,
  output logic [DW-1:0]   mem_addr,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata,
  output logic            mv_start,
  output logic [DW-1:0]   mv_cfg,
  output logic [DW-1:0]   mv_src,
  output logic [DW-1:0]   mv_dst,
  output logic [DW-1:0]   mv_len,
  output logic [DW-1:0]   mv_para,
  output logic [4:0]      mv_src_line,
  output logic            mv_src_fixed,
  output logic [4:0]      mv_src_beats,
  output logic [3:0]      mv_src_bytes,
  output logic [4:0]      mv_dst_line,
  output logic            mv_dst_fixed,
  output logic [4:0]      mv_dst_beats,
  output logic [3:0]      mv_dst_bytes,
  output logic [7:0]      mv_blk_size,
  output logic [7:0]      mv_wait,
  input  logic            mv_done,
  output logic            pkg_done,
  output logic            queue_done
);
  localparam int WORDS = 6;
  localparam int WI_W = $clog2(WORDS);
  localparam logic [RA_W-1:0] OFS_RUN   = RA_W'(8'h00);
  localparam logic [RA_W-1:0] OFS_HOLD  = RA_W'(8'h04);
  localparam logic [RA_W-1:0] OFS_FIRST = RA_W'(8'h08);
  localparam logic [RA_W-1:0] OFS_CFG   = RA_W'(8'h0C);
  localparam logic [RA_W-1:0] OFS_SRC   = RA_W'(8'h10);
  localparam logic [RA_W-1:0] OFS_DST   = RA_W'(8'h14);
  localparam logic [RA_W-1:0] OFS_LEFT  = RA_W'(8'h18);
  localparam logic [RA_W-1:0] OFS_PARA  = RA_W'(8'h1C);
  localparam logic [RA_W-1:0] OFS_CUR   = RA_W'(8'h2C);
  localparam logic [RA_W-1:0] OFS_PKGS  = RA_W'(8'h30);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_MOVE, S_BUSY} st_t;
  st_t st;

  logic [DW-1:0]   first_q, cur_q, left_q;
  logic [DW-1:0]   w_cfg, w_src, w_dst, w_cnt, w_para, w_link;
  logic [WI_W-1:0] widx;
  logic [CNT_W-1:0] pkgs_q;
  logic            pause_q;
  logic            running;
  logic            run_wr;

  assign running  = (st != S_IDLE);
  assign run_wr   = reg_wr_en && (reg_addr == OFS_RUN);
  assign mem_req  = (st == S_FETCH) && !(widx == '0 && pause_q);
  assign mem_addr = cur_q + (DW'(widx) << 2);
  assign mv_start = (st == S_MOVE) && !pause_q;

  assign mv_cfg  = w_cfg;
  assign mv_src  = w_src;
  assign mv_dst  = w_dst;
  assign mv_len  = w_cnt;
  assign mv_para = w_para;

  function automatic logic [4:0] beats_of(input logic [1:0] code);
    case (code)
      2'd0:    beats_of = 5'd1;
      2'd1:    beats_of = 5'd4;
      2'd2:    beats_of = 5'd8;
      default: beats_of = 5'd16;
    endcase
  endfunction

  assign mv_src_line  = w_cfg[4:0];
  assign mv_src_fixed = (w_cfg[6:5] == 2'd1);
  assign mv_src_beats = beats_of(w_cfg[8:7]);
  assign mv_src_bytes = 4'd1 << w_cfg[10:9];
  assign mv_dst_line  = w_cfg[20:16];
  assign mv_dst_fixed = (w_cfg[22:21] == 2'd1);
  assign mv_dst_beats = beats_of(w_cfg[24:23]);
  assign mv_dst_bytes = 4'd1 << w_cfg[26:25];
  assign mv_blk_size  = w_para[15:8];
  assign mv_wait      = w_para[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      first_q    <= '0;
      cur_q      <= '0;
      left_q     <= '0;
      w_cfg      <= '0;
      w_src      <= '0;
      w_dst      <= '0;
      w_cnt      <= '0;
      w_para     <= '0;
      w_link     <= '0;
      widx       <= '0;
      pkgs_q     <= '0;
      pause_q    <= 1'b0;
      pkg_done   <= 1'b0;
      queue_done <= 1'b0;
    end else begin
      pkg_done   <= 1'b0;
      queue_done <= 1'b0;
      if (reg_wr_en && reg_addr == OFS_HOLD)  pause_q <= reg_wdata[0];
      if (reg_wr_en && reg_addr == OFS_FIRST) first_q <= reg_wdata;
      if (run_wr && !reg_wdata[0]) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (run_wr && reg_wdata[0]) begin
            cur_q  <= first_q;
            widx   <= '0;
            pkgs_q <= '0;
            st     <= S_FETCH;
          end
          S_FETCH: if (mem_req && mem_ack) begin
            case (widx)
              WI_W'(0): w_cfg  <= mem_rdata;
              WI_W'(1): w_src  <= mem_rdata;
              WI_W'(2): w_dst  <= mem_rdata;
              WI_W'(3): begin w_cnt <= mem_rdata; left_q <= mem_rdata; end
              WI_W'(4): w_para <= mem_rdata;
              default:  w_link <= mem_rdata;
            endcase
            if (widx == WI_W'(WORDS - 1)) st <= S_MOVE;
            else widx <= widx + 1'b1;
          end
          S_MOVE: if (!pause_q) st <= S_BUSY;
          S_BUSY: if (mv_done) begin
            pkg_done <= 1'b1;
            pkgs_q   <= pkgs_q + 1'b1;
            left_q   <= '0;
            if (w_link == END_MARK) begin
              queue_done <= 1'b1;
              st         <= S_IDLE;
            end else begin
              cur_q <= w_link;
              widx  <= '0;
              st    <= S_FETCH;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_rd_addr)
      OFS_RUN:   reg_rdata = DW'(running);
      OFS_HOLD:  reg_rdata = DW'(pause_q);
      OFS_FIRST: reg_rdata = first_q;
      OFS_CFG:   reg_rdata = w_cfg;
      OFS_SRC:   reg_rdata = w_src;
      OFS_DST:   reg_rdata = w_dst;
      OFS_LEFT:  reg_rdata = left_q;
      OFS_PARA:  reg_rdata = w_para;
      OFS_CUR:   reg_rdata = cur_q;
      OFS_PKGS:  reg_rdata = DW'(pkgs_q);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

module llist_dma_chan_chk #(
  parameter int DW = 32,
  parameter int RA_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr_en,
  input logic [RA_W-1:0] reg_addr,
  input logic [DW-1:0]   reg_wdata,
  input logic            mem_req,
  input logic            mem_ack,
  input logic [DW-1:0]   mem_addr,
  input logic            mv_start,
  input logic            mv_done,
  input logic            pkg_done,
  input logic            queue_done,
  input logic            pause_q,
  input logic            running
);
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (!mem_req || $stable(mem_addr)));

  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mv_start |=> !mv_start);

  p_pkg_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pkg_done |-> $past(mv_done));

  p_queue_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    queue_done |-> (pkg_done && !running));

  p_pause_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> !pause_q);

  p_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == '0 && !reg_wdata[0]) |=> (!running && !pkg_done && !queue_done));
endmodule

bind llist_dma_chan llist_dma_chan_chk #(.DW(DW), .RA_W(RA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mv_start(mv_start), .mv_done(mv_done),
  .pkg_done(pkg_done), .queue_done(queue_done), .pause_q(pause_q),
  .running(running)
);

// File: tb/llist_dma_chan_tb_top.sv
module llist_dma_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [7:0]  reg_rd_addr = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mv_start, pkg_done, queue_done;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] mv_cfg, mv_src, mv_dst, mv_len, mv_para;
  logic [4:0]  mv_src_line, mv_dst_line, mv_src_beats, mv_dst_beats;
  logic        mv_src_fixed, mv_dst_fixed;
  logic [3:0]  mv_src_bytes, mv_dst_bytes;
  logic [7:0]  mv_blk_size, mv_wait;
  logic        mv_done = 1'b0;

  localparam logic [31:0] ENDM = 32'hFFFF_F800;

  always #2 clk = ~clk;

  llist_dma_chan dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rd_addr(reg_rd_addr), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mv_start(mv_start), .mv_cfg(mv_cfg), .mv_src(mv_src), .mv_dst(mv_dst),
    .mv_len(mv_len), .mv_para(mv_para),
    .mv_src_line(mv_src_line), .mv_src_fixed(mv_src_fixed),
    .mv_src_beats(mv_src_beats), .mv_src_bytes(mv_src_bytes),
    .mv_dst_line(mv_dst_line), .mv_dst_fixed(mv_dst_fixed),
    .mv_dst_beats(mv_dst_beats), .mv_dst_bytes(mv_dst_bytes),
    .mv_blk_size(mv_blk_size), .mv_wait(mv_wait), .mv_done(mv_done),
    .pkg_done(pkg_done), .queue_done(queue_done)
  );

  // memory model: acknowledge one cycle after the request, logging each accepted read
  logic [31:0] mem [0:255];
  logic [31:0] rd_log [0:63];
  int          rd_n = 0;
  always @(posedge clk) begin
    mem_ack   <= mem_req && !mem_ack && rst_n;
    mem_rdata <= mem[mem_addr[9:2]];
    if (mem_req && mem_ack) begin
      rd_log[rd_n[5:0]] <= mem_addr;
      rd_n <= rd_n + 1;
    end
  end

  // mover model: logs each start, reports done after mv_lat cycles
  int          mv_lat = 3;
  int          mv_ctr = 0;
  logic        mv_pend = 1'b0;
  int          mv_n = 0;
  logic [31:0] lg_cfg [0:15], lg_src [0:15], lg_dst [0:15], lg_len [0:15], lg_para [0:15];
  logic [31:0] lg_dec [0:15];
  always @(posedge clk) begin
    mv_done <= 1'b0;
    if (mv_start) begin
      lg_cfg[mv_n[3:0]]  <= mv_cfg;
      lg_src[mv_n[3:0]]  <= mv_src;
      lg_dst[mv_n[3:0]]  <= mv_dst;
      lg_len[mv_n[3:0]]  <= mv_len;
      lg_para[mv_n[3:0]] <= mv_para;
      lg_dec[mv_n[3:0]]  <= {mv_src_line, mv_src_fixed, mv_src_beats, mv_src_bytes,
                             mv_dst_line, mv_dst_fixed, mv_dst_beats, mv_dst_bytes, 2'b00};
      mv_n    <= mv_n + 1;
      mv_pend <= 1'b1;
      mv_ctr  <= mv_lat;
    end else if (mv_pend) begin
      if (mv_ctr == 0) begin
        mv_done <= 1'b1;
        mv_pend <= 1'b0;
      end else mv_ctr <= mv_ctr - 1;
    end
  end

  int pkg_n = 0, q_n = 0, qp_n = 0;
  always @(negedge clk) begin
    if (pkg_done) pkg_n <= pkg_n + 1;
    if (queue_done) q_n <= q_n + 1;
    if (queue_done && pkg_done) qp_n <= qp_n + 1;
  end

  int checks = 0, errors = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_rd_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic put_desc(input int at, input logic [31:0] c, input logic [31:0] s,
                          input logic [31:0] d, input logic [31:0] n, input logic [31:0] p,
                          input logic [31:0] link);
    mem[at/4]     = c;
    mem[at/4 + 1] = s;
    mem[at/4 + 2] = d;
    mem[at/4 + 3] = n;
    mem[at/4 + 4] = p;
    mem[at/4 + 5] = link;
  endtask

  task automatic wait_mv(input int target);
    for (int i = 0; i < 400 && mv_n < target; i++) @(negedge clk);
  endtask

  task automatic wait_q(input int target);
    for (int i = 0; i < 2000 && q_n < target; i++) @(negedge clk);
  endtask

  function automatic logic [4:0] ebeats(input logic [1:0] c);
    return (c == 2'd0) ? 5'd1 : (c == 2'd1) ? 5'd4 : (c == 2'd2) ? 5'd8 : 5'd16;
  endfunction

  function automatic logic [31:0] edec(input logic [31:0] c);
    return {c[4:0], c[6:5] == 2'd1, ebeats(c[8:7]), 4'd1 << c[10:9],
            c[20:16], c[22:21] == 2'd1, ebeats(c[24:23]), 4'd1 << c[26:25], 2'b00};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); chk(v == 0, "R1 run bit", v, 0);
    rd(8'h30, v); chk(v == 0, "R1 package counter", v, 0);
    chk(!mem_req && !mv_start, "R1 requests idle", {mem_req, mv_start}, 0);
    chk(!pkg_done && !queue_done, "R1 pulses idle", {pkg_done, queue_done}, 0);
  endtask

  task automatic t_single();
    logic [31:0] v;
    int r0 = rd_n, m0 = mv_n, p0 = pkg_n, q0 = q_n;
    mv_lat = 12;
    put_desc(32'h40, 32'h0501_01AD, 32'h1000_0000, 32'h2000_0040, 32'd96, 32'h0000_3A07, ENDM);
    wr(8'h08, 32'h40);
    wr(8'h00, 1);
    wait_mv(m0 + 1);
    chk(mv_n == m0 + 1, "R3 one start", mv_n, m0 + 1);
    for (int k = 0; k < 6; k++)
      chk(rd_log[(r0 + k) % 64] == 32'h40 + 4 * k, "R2 fetch order", rd_log[(r0 + k) % 64], 32'h40 + 4 * k);
    chk(lg_cfg[m0] == 32'h0501_01AD && lg_src[m0] == 32'h1000_0000, "R3 cfg/src to mover", lg_src[m0], 32'h1000_0000);
    chk(lg_dst[m0] == 32'h2000_0040 && lg_len[m0] == 96 && lg_para[m0] == 32'h3A07, "R3 dst/len/para to mover", lg_dst[m0], 32'h2000_0040);
    chk(lg_dec[m0] == edec(32'h0501_01AD), "R4 decoded fields", lg_dec[m0], edec(32'h0501_01AD));
    chk(mv_blk_size == 8'h3A && mv_wait == 8'h07, "R4 block size and wait", {mv_blk_size, mv_wait}, 32'h3A07);
    rd(8'h18, v); chk(v == 96, "R10 bytes left during transfer", v, 96);
    rd(8'h0C, v); chk(v == 32'h0501_01AD, "R3 cfg readback", v, 32'h0501_01AD);
    rd(8'h14, v); chk(v == 32'h2000_0040, "R3 dst readback", v, 32'h2000_0040);
    rd(8'h1C, v); chk(v == 32'h3A07, "R3 para readback", v, 32'h3A07);
    wait_q(q0 + 1);
    chk(pkg_n == p0 + 1 && q_n == q0 + 1, "R7 one package one queue", pkg_n - p0, 1);
    rd(8'h00, v); chk(v == 0, "R7 run bit cleared", v, 0);
    rd(8'h30, v); chk(v == 1, "R5 package counter", v, 1);
    rd(8'h18, v); chk(v == 0, "R10 bytes left after done", v, 0);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    int m0 = mv_n, p0 = pkg_n, q0 = q_n, qp0 = qp_n, r0 = rd_n;
    logic [31:0] c [3] = '{32'h0623_0040, 32'h0080_3E9F, 32'h0781_0602};
    mv_lat = 2;
    put_desc(32'h80,  c[0], 32'hA0, 32'hB0, 32'd8,  32'h0101, 32'h100);
    put_desc(32'h100, c[1], 32'hA1, 32'hB1, 32'd16, 32'h0202, 32'h20);
    put_desc(32'h20,  c[2], 32'hA2, 32'hB2, 32'd24, 32'h0303, ENDM);
    wr(8'h08, 32'h80);
    wr(8'h00, 1);
    wait_q(q0 + 1);
    chk(mv_n == m0 + 3, "R6 three descriptors", mv_n - m0, 3);
    for (int k = 0; k < 3; k++) begin
      chk(lg_src[m0 + k] == 32'hA0 + k && lg_len[m0 + k] == 8 * (k + 1), "R6 link order", lg_src[m0 + k], 32'hA0 + k);
      chk(lg_dec[m0 + k] == edec(c[k]), "R4 decoded fields per descriptor", lg_dec[m0 + k], edec(c[k]));
    end
    chk(rd_log[(r0 + 12) % 64] == 32'h20, "R6 third fetch address", rd_log[(r0 + 12) % 64], 32'h20);
    chk(pkg_n == p0 + 3, "R5 three package pulses", pkg_n - p0, 3);
    chk(q_n == q0 + 1 && qp_n == qp0 + 1, "R7 queue with package", qp_n - qp0, 1);
    rd(8'h30, v); chk(v == 3, "R5 package counter", v, 3);
    rd(8'h2C, v); chk(v == 32'h20, "R6 current descriptor", v, 32'h20);
  endtask

  task automatic t_pause();
    logic [31:0] v;
    int r0 = rd_n, m0 = mv_n, p0 = pkg_n, q0 = q_n;
    mv_lat = 20;
    put_desc(32'h200, 32'h0000_0001, 32'hC0, 32'hD0, 32'd4, 0, 32'h240);
    put_desc(32'h240, 32'h0001_0000, 32'hC1, 32'hD1, 32'd4, 0, ENDM);
    wr(8'h04, 1);
    wr(8'h08, 32'h200);
    wr(8'h00, 1);
    repeat (40) @(negedge clk);
    chk(rd_n == r0 && mv_n == m0, "R8 no fetch while paused", rd_n - r0, 0);
    rd(8'h00, v); chk(v == 1, "R8 run bit while paused", v, 1);
    wr(8'h04, 0);
    wait_mv(m0 + 1);
    wr(8'h04, 1);
    repeat (60) @(negedge clk);
    chk(pkg_n == p0 + 1, "R8 in-flight transfer finishes", pkg_n - p0, 1);
    chk(mv_n == m0 + 1 && rd_n == r0 + 6, "R8 next fetch held", rd_n - r0, 6);
    wr(8'h04, 0);
    wait_q(q0 + 1);
    chk(q_n == q0 + 1 && mv_n == m0 + 2, "R8 resume completes chain", mv_n - m0, 2);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    int m0 = mv_n, p0 = pkg_n, q0 = q_n;
    mv_lat = 25;
    put_desc(32'h300, 32'h0, 32'hE0, 32'hF0, 32'd32, 0, 32'h340);
    put_desc(32'h340, 32'h0, 32'hE1, 32'hF1, 32'd32, 0, ENDM);
    wr(8'h08, 32'h300);
    wr(8'h00, 1);
    wait_mv(m0 + 1);
    wr(8'h00, 0);
    rd(8'h00, v); chk(v == 0, "R9 run bit after stop", v, 0);
    chk(!mem_req && !mv_start, "R9 no requests after stop", {mem_req, mv_start}, 0);
    repeat (60) @(negedge clk);
    chk(pkg_n == p0 && q_n == q0, "R9 no pulses after stop", pkg_n - p0, 0);
    chk(mv_n == m0 + 1, "R9 no further start", mv_n - m0, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_chain();
    t_pause();
    t_abort();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule